// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block turns requests from an internal bus master into bus cycles on a time-multiplexed external bus. Each bus cycle has two halves, marked by the generated bus clock. In the high half the address lines carry the full address. In the low half the upper address lines carry an access-type code and the queue status of the previous access. The low sixteen lines carry internal-visibility data for an internal read, and the address again for any other access. External writes pull the read/write strobe low and drive the data bus. Reads leave the data bus undriven.

The access length depends on the region and the operating mode. Port-replacement registers always take two bus cycles. Emulation memory always takes one. Other external targets in the two expanded modes take one cycle plus a programmable stretch. A port-replacement write in an emulation mode updates the internal register and also goes out on the bus. A port-replacement read in an emulation mode is served from the external data bus. The master sees a ready signal that is high only in the low half of the final cycle, or while idle. Accesses may follow one another with no idle cycle in between.

Top module: `xbus_seq`

## Requirements
- R1: In the high half of every bus cycle of an access (eclk_o = 1), xaddr_o equals the latched 23-bit access address.
- R2: In the low half, xaddr_o[22:20] carries the latched access-type code and xaddr_o[19:16] carries the queue status of the previous accepted access. The status is 0 for the first access after reset.
- R3: For an internal read, xaddr_o[15:0] in the low half carries visibility data built from int_rdata_i. For a word read, int_rdata_i[15:8] is the byte at the access address A and int_rdata_i[7:0] is the byte at A+1; for a byte read, int_rdata_i[7:0] is the byte at A. Each even-address byte goes on lane [15:8] and each odd-address byte on lane [7:0]. In a byte read, the unused lane repeats the matching half of addr[15:0].
- R4: For every access other than an internal read, xaddr_o[15:0] in the low half repeats addr[15:0].
- R5: An externally directed write holds rw_o low for the whole access and drives wdata on data_o with data_oe_o high in each low half. A read keeps rw_o high and data_oe_o low.
- R6: A port-replacement access (is_prr_i) takes exactly two bus cycles in every mode, regardless of stretch_i.
- R7: In an emulation mode (mode_i[1] = 1), a port-replacement write is driven externally and a port-replacement read returns data_i. Outside emulation, a port-replacement write leaves rw_o high and a port-replacement read returns int_rdata_i with visibility data. A port-replacement write pulses prr_we_o in its final low half in every mode.
- R8: In an expanded mode (mode_i[0] = 1), an external access outside emulation memory and port-replacement space takes 1 + stretch_i bus cycles.
- R9: An emulation-memory access (is_emem_i) takes one bus cycle. Any access in a non-expanded mode (mode_i[0] = 0) also takes one cycle, except a port-replacement access.
- R10: ready_o is high only in a low half, either while idle or in the final cycle of an access. done_o marks the final low half, and there rdata_o holds the read result.
- R11: During reset and while idle, xaddr_o is 0, rw_o is 1 and data_oe_o is 0. The bus clock starts in its high half.
- R12: A request held while ready_o is high starts in the very next bus cycle, so read, write and read can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, two per bus cycle |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | bit1 emulation, bit0 expanded |
| stretch_i | input | STR_W | Extra cycles for stretched external accesses |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 write, 0 read |
| word_i | input | 1 | 1 word, 0 byte |
| addr_i | input | AW | Access address |
| acc_i | input | ACC_W | Access-type code |
| iqstat_i | input | IQ_W | Queue status of this access |
| wdata_i | input | DW | Write data |
| is_int_i | input | 1 | Target is internal |
| is_prr_i | input | 1 | Target is a port-replacement register |
| is_emem_i | input | 1 | Target is emulation memory |
| int_rdata_i | input | DW | Internal read data |
| data_i | input | DW | External data bus input |
| ready_o | output | 1 | Request may be taken this cycle |
| done_o | output | 1 | Final low half of an access |
| rdata_o | output | DW | Read result, valid with done_o |
| prr_we_o | output | 1 | Internal port-replacement register write strobe |
| eclk_o | output | 1 | Bus clock, high in the address half |
| xaddr_o | output | AW | Multiplexed address lines |
| rw_o | output | 1 | Read/write strobe, low for write |
| data_o | output | DW | External data bus output |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with its default parameters: 16 data bits, a 23-bit address and a 2-bit stretch field. Stretch values up to three extra cycles are therefore within reach, and the bench compares the fixed two-cycle port-replacement length against the longest stretch. Both byte lanes of the visibility data are checked for aligned and misaligned words and for byte reads at both parities. The three-bit access code and four-bit queue status are driven with distinct values, so the one-access lag of the queue status shows at the ports.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        MD_SINGLE  = 2'b00,
        MD_NEXP    = 2'b01,
        MD_ESINGLE = 2'b10,
        MD_EEXP    = 2'b11
    } xbus_mode_e;

    function automatic logic mode_emul(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic mode_expanded(input logic [1:0] m);
        return m[0];
    endfunction
endpackage

// File: rtl/xbus_cyc_len.sv
module xbus_cyc_len #(
    parameter int STR_W = 2
) (
    input  logic [1:0]       mode_i,
    input  logic [STR_W-1:0] stretch_i,
    input  logic             is_int_i,
    input  logic             is_prr_i,
    input  logic             is_emem_i,
    output logic [STR_W-1:0] extra_o,
    output logic             str_ok_o,
    output logic             ext_o
);
    import xbus_pkg::*;

    always_comb begin
        str_ok_o = mode_expanded(mode_i) && !is_int_i && !is_prr_i && !is_emem_i;
        ext_o    = is_prr_i ? mode_emul(mode_i) : !is_int_i;
        if (is_prr_i)
            extra_o = STR_W'(1);
        else if (str_ok_o)
            extra_o = stretch_i;
        else
            extra_o = '0;
    end
endmodule

// File: rtl/xbus_ivd_lane.sv
module xbus_ivd_lane #(
    parameter int DW = 16
) (
    input  logic          word_i,
    input  logic [DW-1:0] addr_lo_i,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] ivd_o
);
    localparam int BW = DW / 2;

    always_comb begin
        if (word_i)
            ivd_o = addr_lo_i[0] ? {rdata_i[BW-1:0], rdata_i[DW-1:BW]} : rdata_i;
        else if (addr_lo_i[0])
            ivd_o = {addr_lo_i[DW-1:BW], rdata_i[BW-1:0]};
        else
            ivd_o = {rdata_i[BW-1:0], addr_lo_i[BW-1:0]};
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
    parameter int DW    = 16,
    parameter int ACC_W = 3,
    parameter int IQ_W  = 4,
    parameter int STR_W = 2,
    localparam int AW   = DW + IQ_W + ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [STR_W-1:0] stretch_i,
    input  logic             req_i,
    input  logic             we_i,
    input  logic             word_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [IQ_W-1:0]  iqstat_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             is_int_i,
    input  logic             is_prr_i,
    input  logic             is_emem_i,
    input  logic [DW-1:0]    int_rdata_i,
    input  logic [DW-1:0]    data_i,
    output logic             ready_o,
    output logic             done_o,
    output logic [DW-1:0]    rdata_o,
    output logic             prr_we_o,
    output logic             eclk_o,
    output logic [AW-1:0]    xaddr_o,
    output logic             rw_o,
    output logic [DW-1:0]    data_o,
    output logic             data_oe_o
);
    typedef struct packed {
        logic             phase;
        logic             busy;
        logic [STR_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic             we;
        logic             word;
        logic [ACC_W-1:0] acc;
        logic [IQ_W-1:0]  iq_cur;
        logic [IQ_W-1:0]  iq_prev;
        logic [DW-1:0]    wdata;
        logic             ext;
        logic             prr;
        logic             emem;
        logic             str_ok;
        logic [STR_W-1:0] str;
    } seq_t;

    seq_t st_d, st_q;

    logic [STR_W-1:0] extra_w;
    logic             str_ok_w;
    logic             ext_w;
    logic [DW-1:0]    ivd_w;
    logic             last_w;
    logic             accept_w;
    logic             int_rd_w;
    logic             ext_wr_w;

    xbus_cyc_len #(.STR_W(STR_W)) u_len (
        .mode_i   (mode_i),
        .stretch_i(stretch_i),
        .is_int_i (is_int_i),
        .is_prr_i (is_prr_i),
        .is_emem_i(is_emem_i),
        .extra_o  (extra_w),
        .str_ok_o (str_ok_w),
        .ext_o    (ext_w)
    );

    xbus_ivd_lane #(.DW(DW)) u_ivd (
        .word_i   (st_q.word),
        .addr_lo_i(st_q.addr[DW-1:0]),
        .rdata_i  (int_rdata_i),
        .ivd_o    (ivd_w)
    );

    always_comb begin
        last_w   = st_q.busy && (st_q.cnt == '0);
        ready_o  = st_q.phase && (!st_q.busy || (st_q.cnt == '0));
        accept_w = ready_o && req_i;

        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        if (st_q.phase && st_q.busy && (st_q.cnt != '0))
            st_d.cnt = st_q.cnt - STR_W'(1);
        if (st_q.phase && last_w)
            st_d.busy = 1'b0;
        if (accept_w) begin
            st_d.busy    = 1'b1;
            st_d.cnt     = extra_w;
            st_d.addr    = addr_i;
            st_d.we      = we_i;
            st_d.word    = word_i;
            st_d.acc     = acc_i;
            st_d.iq_prev = st_q.iq_cur;
            st_d.iq_cur  = iqstat_i;
            st_d.wdata   = wdata_i;
            st_d.ext     = ext_w;
            st_d.prr     = is_prr_i;
            st_d.emem    = is_emem_i;
            st_d.str_ok  = str_ok_w;
            st_d.str     = stretch_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        int_rd_w  = !st_q.we && !st_q.ext;
        ext_wr_w  = st_q.busy && st_q.we && st_q.ext;
        eclk_o    = ~st_q.phase;
        done_o    = st_q.phase && last_w;
        rw_o      = !ext_wr_w;
        data_oe_o = ext_wr_w && st_q.phase;
        data_o    = data_oe_o ? st_q.wdata : '0;
        prr_we_o  = done_o && st_q.we && st_q.prr;
        if (st_q.busy && !st_q.we)
            rdata_o = st_q.ext ? data_i : int_rdata_i;
        else
            rdata_o = '0;
        if (!st_q.busy)
            xaddr_o = '0;
        else if (!st_q.phase)
            xaddr_o = st_q.addr;
        else
            xaddr_o = {st_q.acc, st_q.iq_prev, int_rd_w ? ivd_w : st_q.addr[DW-1:0]};
    end
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
    parameter int STR_W = 2,
    parameter int IQ_W  = 4,
    parameter int AW    = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             req,
    input logic             done,
    input logic             eclk,
    input logic             rw,
    input logic             oe,
    input logic             prr_we,
    input logic [AW-1:0]    xaddr,
    input logic             busy,
    input logic             prr,
    input logic             emem,
    input logic             str_ok,
    input logic [STR_W-1:0] str,
    input logic [IQ_W-1:0]  iq_cur,
    input logic [IQ_W-1:0]  iq_prev
);
    localparam int CW = STR_W + 2;

    logic [CW-1:0] low_cnt;
    logic [CW-1:0] exp_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (busy && !eclk)
            low_cnt <= done ? '0 : low_cnt + CW'(1);
    end

    always_comb begin
        if (prr)
            exp_len = CW'(2);
        else if (emem)
            exp_len = CW'(1);
        else if (str_ok)
            exp_len = CW'(str) + CW'(1);
        else
            exp_len = CW'(1);
    end

    p_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (low_cnt + CW'(1) == exp_len));

    p_oe_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !rw);

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rw && !oe && xaddr == '0));

    p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !eclk);

    p_iq_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> (iq_prev == $past(iq_cur)));

    p_prr_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prr_we |-> done);
endmodule

bind xbus_seq xbus_seq_chk #(.STR_W(STR_W), .IQ_W(IQ_W), .AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready  (ready_o),
    .req    (req_i),
    .done   (done_o),
    .eclk   (eclk_o),
    .rw     (rw_o),
    .oe     (data_oe_o),
    .prr_we (prr_we_o),
    .xaddr  (xaddr_o),
    .busy   (st_q.busy),
    .prr    (st_q.prr),
    .emem   (st_q.emem),
    .str_ok (st_q.str_ok),
    .str    (st_q.str),
    .iq_cur (st_q.iq_cur),
    .iq_prev(st_q.iq_prev)
);

// File: tb/xbus_seq_bench.sv
module xbus_seq_bench;
    localparam int DW = 16;
    localparam int AW = 23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = '0;
    logic [1:0]    stretch_i = '0;
    logic          req_i = 1'b0;
    logic          we_i = 1'b0;
    logic          word_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [2:0]    acc_i = '0;
    logic [3:0]    iqstat_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic          is_int_i = 1'b0;
    logic          is_prr_i = 1'b0;
    logic          is_emem_i = 1'b0;
    logic [DW-1:0] int_rdata_i = '0;
    logic [DW-1:0] data_i = '0;
    logic          ready_o, done_o, prr_we_o, eclk_o, rw_o, data_oe_o;
    logic [DW-1:0] rdata_o, data_o;
    logic [AW-1:0] xaddr_o;

    int checks = 0;
    int failures = 0;
    logic [3:0] iq_prev_m = '0;

    typedef struct {
        string         tag;
        logic [AW-1:0] xaddr;
        logic          eclk;
        logic          rw;
        logic          oe;
        logic [DW-1:0] dout;
        logic          ready;
        logic          done;
        logic          chk_rd;
        logic [DW-1:0] rdata;
        logic          prr_we;
    } item_t;

    item_t exp_q[$];

    always #10 clk = ~clk;

    xbus_seq u_xbus_seq (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .stretch_i(stretch_i),
        .req_i(req_i), .we_i(we_i), .word_i(word_i), .addr_i(addr_i),
        .acc_i(acc_i), .iqstat_i(iqstat_i), .wdata_i(wdata_i),
        .is_int_i(is_int_i), .is_prr_i(is_prr_i), .is_emem_i(is_emem_i),
        .int_rdata_i(int_rdata_i), .data_i(data_i), .ready_o(ready_o),
        .done_o(done_o), .rdata_o(rdata_o), .prr_we_o(prr_we_o),
        .eclk_o(eclk_o), .xaddr_o(xaddr_o), .rw_o(rw_o),
        .data_o(data_o), .data_oe_o(data_oe_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ivd_model(input logic word, input logic [15:0] a,
                                                input logic [DW-1:0] rd);
        logic [7:0] hi_lane, lo_lane;
        hi_lane = a[15:8];
        lo_lane = a[7:0];
        if (word) begin
            if (a[0]) begin lo_lane = rd[15:8]; hi_lane = rd[7:0]; end
            else      begin hi_lane = rd[15:8]; lo_lane = rd[7:0]; end
        end else begin
            if (a[0]) lo_lane = rd[7:0];
            else      hi_lane = rd[7:0];
        end
        return {hi_lane, lo_lane};
    endfunction

    task automatic run_acc(input string tag, input logic [1:0] md, input logic [1:0] st,
                           input logic we, input logic word, input logic [AW-1:0] a,
                           input logic [2:0] acc, input logic [3:0] iq, input logic [15:0] wd,
                           input logic isint, input logic isprr, input logic isemem,
                           input logic [15:0] ird, input logic [15:0] xd);
        logic ext;
        int n;
        item_t it;
        @(negedge clk); #1;
        while (!ready_o) begin @(negedge clk); #1; end
        ext = isprr ? md[1] : !isint;
        if (isprr) n = 2;
        else if (isemem) n = 1;
        else if (md[0] && !isint) n = int'(st) + 1;
        else n = 1;
        for (int i = 0; i < n; i++) begin
            it.tag = tag; it.eclk = 1'b1; it.xaddr = a; it.rw = !(we && ext);
            it.oe = 1'b0; it.dout = '0; it.ready = 1'b0; it.done = 1'b0;
            it.chk_rd = 1'b0; it.rdata = '0; it.prr_we = 1'b0;
            exp_q.push_back(it);
            it.eclk = 1'b0;
            it.xaddr = {acc, iq_prev_m, (!we && !ext) ? ivd_model(word, a[15:0], ird) : a[15:0]};
            it.oe = we && ext; it.dout = it.oe ? wd : '0;
            it.done = (i == n - 1); it.ready = it.done;
            it.chk_rd = it.done && !we; it.rdata = ext ? xd : ird;
            it.prr_we = it.done && we && isprr;
            exp_q.push_back(it);
        end
        iq_prev_m = iq;
        mode_i = md; stretch_i = st; we_i = we; word_i = word; addr_i = a;
        acc_i = acc; iqstat_i = iq; wdata_i = wd; is_int_i = isint;
        is_prr_i = isprr; is_emem_i = isemem; int_rdata_i = ird; data_i = xd;
        req_i = 1'b1;
        @(posedge clk); #1;
        req_i = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                chk(e.tag, "eclk", 32'(eclk_o), 32'(e.eclk));
                chk(e.tag, "xaddr", 32'(xaddr_o), 32'(e.xaddr));
                chk(e.tag, "rw", 32'(rw_o), 32'(e.rw));
                chk(e.tag, "oe", 32'(data_oe_o), 32'(e.oe));
                if (e.oe) chk(e.tag, "data_o", 32'(data_o), 32'(e.dout));
                chk(e.tag, "ready", 32'(ready_o), 32'(e.ready));
                chk(e.tag, "done", 32'(done_o), 32'(e.done));
                if (e.chk_rd) chk(e.tag, "rdata", 32'(rdata_o), 32'(e.rdata));
                chk(e.tag, "prr_we", 32'(prr_we_o), 32'(e.prr_we));
            end else begin
                chk("R11", "idle xaddr/rw/oe", {xaddr_o, rw_o, data_oe_o}, {23'd0, 1'b1, 1'b0});
            end
        end
    end

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset outputs", {xaddr_o, rw_o, data_oe_o, eclk_o}, {23'd0, 1'b1, 1'b0, 1'b1});
        rst_n = 1'b1;
        // R1 R4 R5: external word read, normal expanded, no stretch
        run_acc("R1", 2'b01, 2'd0, 0, 1, 23'h5A_1234, 3'd5, 4'hA, 16'h0, 0, 0, 0, 16'h0, 16'hBEEF);
        // R8 R5: stretched external write
        run_acc("R8", 2'b01, 2'd2, 1, 1, 23'h12_3456, 3'd3, 4'h6, 16'hC0DE, 0, 0, 0, 16'h0, 16'h0);
        run_acc("R8", 2'b11, 2'd3, 0, 0, 23'h01_0011, 3'd1, 4'h2, 16'h0, 0, 0, 0, 16'h0, 16'h00A5);
        // R3: internal visibility, all lane cases
        run_acc("R3", 2'b01, 2'd3, 0, 1, 23'h00_4410, 3'd2, 4'h1, 16'h0, 1, 0, 0, 16'h1122, 16'h0);
        run_acc("R3", 2'b01, 2'd3, 0, 1, 23'h00_4411, 3'd6, 4'h3, 16'h0, 1, 0, 0, 16'h3344, 16'h0);
        run_acc("R3", 2'b00, 2'd0, 0, 0, 23'h00_ABCE, 3'd7, 4'h5, 16'h0, 1, 0, 0, 16'h0077, 16'h0);
        run_acc("R3", 2'b00, 2'd0, 0, 0, 23'h00_ABCF, 3'd4, 4'h9, 16'h0, 1, 0, 0, 16'h0099, 16'h0);
        // R12 R2: back-to-back read-write-read
        run_acc("R12", 2'b01, 2'd0, 0, 1, 23'h70_0100, 3'd1, 4'hB, 16'h0, 0, 0, 0, 16'h0, 16'h1357);
        run_acc("R12", 2'b01, 2'd0, 1, 1, 23'h70_0102, 3'd2, 4'hC, 16'h2468, 0, 0, 0, 16'h0, 16'h0);
        run_acc("R2", 2'b01, 2'd0, 0, 1, 23'h70_0104, 3'd3, 4'hD, 16'h0, 0, 0, 0, 16'h0, 16'h9ABC);
        // R6 R7: port-replacement, non-emulation then emulation
        run_acc("R6", 2'b01, 2'd3, 1, 0, 23'h00_0001, 3'd0, 4'h4, 16'h00F1, 0, 1, 0, 16'h0, 16'h0);
        run_acc("R7", 2'b00, 2'd0, 0, 1, 23'h00_0002, 3'd5, 4'h7, 16'h0, 0, 1, 0, 16'h5566, 16'hDEAD);
        run_acc("R7", 2'b11, 2'd3, 1, 1, 23'h00_0004, 3'd6, 4'h8, 16'hFACE, 0, 1, 0, 16'h0, 16'h0);
        run_acc("R7", 2'b10, 2'd2, 0, 1, 23'h00_0006, 3'd7, 4'hE, 16'h0, 0, 1, 0, 16'h7788, 16'hCAFE);
        // R9: emulation memory and non-expanded mode ignore stretch
        run_acc("R9", 2'b11, 2'd3, 0, 1, 23'h40_2000, 3'd1, 4'hF, 16'h0, 0, 0, 1, 16'h0, 16'h4321);
        run_acc("R9", 2'b10, 2'd3, 1, 1, 23'h40_2002, 3'd2, 4'h0, 16'h8765, 0, 0, 0, 16'h0, 16'h0);
        // R10: ready/done across an access with stretch 1
        run_acc("R10", 2'b01, 2'd1, 0, 1, 23'h33_3332, 3'd4, 4'h3, 16'h0, 0, 0, 0, 16'h0, 16'h0F0F);
        while (exp_q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        #1;
        chk("R10", "idle ready in low half", 32'(ready_o), 32'(!eclk_o));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule